// File: doc/BRIEF.md
# Size-Aware Register-to-Register ALU

This block runs one two-operand integer operation per cycle on a 32-bit destination value and a 32-bit source value. Each operation is carried out at byte, word or dword width, chosen by a 2-bit size code. It covers add, subtract, compare, negate, AND, OR, move, arithmetic shift right, logical shift right and logical shift left. When a byte or word result is written back, only the low 8 or 16 bits of the destination change. The upper bits come back as they were.

A core's execute stage drives the destination and source register values together with an operation code, a size code and a valid strobe. One cycle later the block returns the new destination value, a write enable and the four condition flags N, Z, V and C. N, Z and V are always taken at the operation width and never from the merged 32-bit value.

Top module: `rrs_alu`

## Requirements
- R1: The result is registered. When `op_valid` is high at a clock edge, `res_valid` is high after that edge and `res_wen`, `res_val` and the flags reflect that operation. When `op_valid` is low, `res_valid` and `res_wen` are low after the edge. Reset clears every output to zero.
- R2: Size codes are 00 byte, 01 word, and 10 or 11 dword. For every operation that writes, a byte result replaces only `res_val[7:0]` and a word result replaces only `res_val[15:0]`. The remaining bits equal the corresponding bits of `dst_val`.
- R3: Operation codes are 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 negate, 6 arithmetic shift right, 7 logical shift right, 8 logical shift left and 9 move. Add writes dst+src and subtract writes dst-src, both at the operation size. C is the carry out of the sized add or the borrow of the sized subtract. V flags signed overflow at that size.
- R4: Compare sets N, Z, V and C exactly as subtract would. It keeps `res_wen` low and returns `dst_val` unchanged on `res_val`.
- R5: Negate writes 0-src at the operation size. V is set only when the sized source is the most negative value, and C is set when the sized source is nonzero.
- R6: AND writes dst&src, OR writes dst|src and move writes src, all at the operation size. They clear V and C.
- R7: Arithmetic shift right sign-extends the sized destination to 32 bits. It then shifts right by src[5:0], with any count above 31 treated as 31, and truncates the result back to the operation size. V and C are cleared.
- R8: Logical shifts zero-extend the sized destination. They shift by src[5:0] and return zero when that count is 32 or more, and the result is truncated to the operation size. V and C are cleared.
- R9: N is the top bit of the sized result and Z is set when the sized result is zero. For compare, the sized result is the difference.
- R10: Operation codes 10 to 15 leave `res_wen` low, return `dst_val` on `res_val` and clear all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| op_size | input | 2 | Operand size code |
| dst_val | input | 32 | Current destination register value |
| src_val | input | 32 | Source register value |
| res_valid | output | 1 | Result present |
| res_wen | output | 1 | Destination write enable |
| res_val | output | 32 | New destination value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry or borrow flag |

## Verification
The sweep crosses every operation and size with operands placed at the sign and carry boundaries of each width: 0x7F/0x80, 0x7FFF/0x8000 and the full-width extremes, with upper bits set in the destination. A design that took the carry or sign from bit 31 instead of the operation width gives wrong C, V or N on byte and word sums. A design that wrote a narrow result without merging clears the preserved upper bits. A separate count sweep from 0 to 70 on all three shifts targets the count handling. Counts of 32 and above catch a design that masks a logical-shift count to five bits, because its result does not go to zero. Byte and word arithmetic shifts catch a design that sign-extends from bit 31, because its result takes ones in place of the sized sign.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int XLEN   = 32;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int OP_W   = 4;
  localparam int SIZE_W = 2;
  localparam int CNT_W  = $clog2(XLEN) + 1;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_NEG  = 4'd5,
    OP_ASR  = 4'd6,
    OP_LSR  = 4'd7,
    OP_LSL  = 4'd8,
    OP_MOVE = 4'd9
  } rrs_op_e;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_DALT  = 2'd3
  } rrs_size_e;

  function automatic logic [XLEN-1:0] size_mask(input rrs_size_e s);
    case (s)
      SZ_BYTE: return {{(XLEN-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
      SZ_WORD: return {{(XLEN-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      default: return {XLEN{1'b1}};
    endcase
  endfunction

  function automatic logic [XLEN-1:0] zext_sz(input logic [XLEN-1:0] v, input rrs_size_e s);
    return v & size_mask(s);
  endfunction

  function automatic logic [XLEN-1:0] sext_sz(input logic [XLEN-1:0] v, input rrs_size_e s);
    case (s)
      SZ_BYTE: return {{(XLEN-BYTE_W){v[BYTE_W-1]}}, v[BYTE_W-1:0]};
      SZ_WORD: return {{(XLEN-HALF_W){v[HALF_W-1]}}, v[HALF_W-1:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic msb_sz(input logic [XLEN-1:0] v, input rrs_size_e s);
    case (s)
      SZ_BYTE: return v[BYTE_W-1];
      SZ_WORD: return v[HALF_W-1];
      default: return v[XLEN-1];
    endcase
  endfunction

  function automatic logic [XLEN-1:0] merge_sz(input logic [XLEN-1:0] dst,
                                              input logic [XLEN-1:0] r,
                                              input rrs_size_e s);
    logic [XLEN-1:0] m;
    m = size_mask(s);
    return (dst & ~m) | (r & m);
  endfunction

  function automatic logic op_known(input logic [OP_W-1:0] code);
    return code <= OP_W'(OP_MOVE);
  endfunction
endpackage

// File: rtl/rrs_addsub.sv
module rrs_addsub
  import rrs_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  rrs_op_e         op,
  input  rrs_size_e       size,
  output logic [XLEN-1:0] res,
  output logic            ovf,
  output logic            cry
);
  logic [XLEN-1:0] x, y;
  logic [XLEN:0]   sum, dif;
  logic            is_sub, carry_out, sx, sy, sr;

  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_CMP) || (op == OP_NEG);
    x      = (op == OP_NEG) ? '0 : zext_sz(a, size);
    y      = zext_sz(b, size);
    sum    = {1'b0, x} + {1'b0, y};
    dif    = {1'b0, x} - {1'b0, y};
    res    = zext_sz(is_sub ? dif[XLEN-1:0] : sum[XLEN-1:0], size);
    case (size)
      SZ_BYTE: carry_out = sum[BYTE_W];
      SZ_WORD: carry_out = sum[HALF_W];
      default: carry_out = sum[XLEN];
    endcase
    // masked operands: a negative difference always sets the top bit
    cry = is_sub ? dif[XLEN] : carry_out;
    sx  = msb_sz(x, size);
    sy  = msb_sz(y, size);
    sr  = msb_sz(res, size);
    ovf = is_sub ? ((sx != sy) && (sr != sx)) : ((sx == sy) && (sr != sx));
  end
endmodule

// File: rtl/rrs_logic.sv
module rrs_logic
  import rrs_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  rrs_op_e         op,
  input  rrs_size_e       size,
  output logic [XLEN-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = zext_sz(a & b, size);
      OP_OR:   res = zext_sz(a | b, size);
      default: res = zext_sz(b, size);
    endcase
  end
endmodule

// File: rtl/rrs_shift.sv
module rrs_shift
  import rrs_pkg::*;
(
  input  logic [XLEN-1:0]  a,
  input  logic [CNT_W-1:0] cnt,
  input  rrs_op_e          op,
  input  rrs_size_e        size,
  output logic [XLEN-1:0]  res
);
  localparam int SH_W = CNT_W - 1;
  logic [SH_W-1:0] asr_cnt;
  logic            big;
  logic [XLEN-1:0] sx, zx, raw;

  always_comb begin
    big     = cnt[CNT_W-1];
    asr_cnt = big ? {SH_W{1'b1}} : cnt[SH_W-1:0];
    sx      = sext_sz(a, size);
    zx      = zext_sz(a, size);
    case (op)
      OP_ASR:  raw = XLEN'($signed(sx) >>> asr_cnt);
      OP_LSR:  raw = big ? '0 : (zx >> cnt[SH_W-1:0]);
      default: raw = big ? '0 : (zx << cnt[SH_W-1:0]);
    endcase
    res = zext_sz(raw, size);
  end
endmodule

// File: rtl/rrs_alu.sv
module rrs_alu
  import rrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [SIZE_W-1:0] op_size,
  input  logic [XLEN-1:0]   dst_val,
  input  logic [XLEN-1:0]   src_val,
  output logic              res_valid,
  output logic              res_wen,
  output logic [XLEN-1:0]   res_val,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);
  rrs_op_e   op;
  rrs_size_e sz;
  assign op = rrs_op_e'(op_code);
  assign sz = rrs_size_e'(op_size);

  // named internal events
  logic            known, is_arith, is_shift, writes;
  logic [XLEN-1:0] arith_res, logic_res, shift_res, sized_res, next_val;
  logic            arith_v, arith_c, next_n, next_z, next_v, next_c;

  rrs_addsub u_addsub (
    .a(dst_val), .b(src_val), .op(op), .size(sz),
    .res(arith_res), .ovf(arith_v), .cry(arith_c)
  );

  rrs_logic u_logic (
    .a(dst_val), .b(src_val), .op(op), .size(sz), .res(logic_res)
  );

  rrs_shift u_shift (
    .a(dst_val), .cnt(src_val[CNT_W-1:0]), .op(op), .size(sz), .res(shift_res)
  );

  always_comb begin
    known    = op_known(op_code);
    is_arith = known && (op == OP_ADD || op == OP_SUB || op == OP_CMP || op == OP_NEG);
    is_shift = known && (op == OP_ASR || op == OP_LSR || op == OP_LSL);
    writes   = known && (op != OP_CMP);
    if (is_arith)      sized_res = arith_res;
    else if (is_shift) sized_res = shift_res;
    else               sized_res = logic_res;
    next_val = writes ? merge_sz(dst_val, sized_res, sz) : dst_val;
    next_n   = known && msb_sz(sized_res, sz);
    next_z   = known && (sized_res == '0);
    next_v   = is_arith && arith_v;
    next_c   = is_arith && arith_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_wen   <= 1'b0;
      res_val   <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      res_valid <= op_valid;
      res_wen   <= op_valid && writes;
      if (op_valid) begin
        res_val <= next_val;
        flag_n  <= next_n;
        flag_z  <= next_z;
        flag_v  <= next_v;
        flag_c  <= next_c;
      end
    end
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  p_idle_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && !res_wen));
  p_byte_upper_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_size == 2'd0 && op_known(op_code) && op_code != 4'd2)
      |=> (res_val[XLEN-1:BYTE_W] == $past(dst_val[XLEN-1:BYTE_W])));
  p_word_upper_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_size == 2'd1 && op_known(op_code) && op_code != 4'd2)
      |=> (res_val[XLEN-1:HALF_W] == $past(dst_val[XLEN-1:HALF_W])));
  p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd2) |=> (!res_wen && res_val == $past(dst_val)));
  p_logic_clears_vc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd3 || op_code == 4'd4 || op_code == 4'd9))
      |=> (!flag_v && !flag_c));
  p_shift_clears_vc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd6 || op_code == 4'd7 || op_code == 4'd8))
      |=> (!flag_v && !flag_c));
  p_byte_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_size == 2'd0 && op_known(op_code) && op_code != 4'd2)
      |=> (flag_z == (res_val[BYTE_W-1:0] == '0)));
  p_undef_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_known(op_code))
      |=> (!res_wen && res_val == $past(dst_val) && !flag_n && !flag_z && !flag_v && !flag_c));
endmodule

// File: tb/test_rrs_alu.sv
`timescale 1ns/1ps
module test_rrs_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [1:0]  op_size = '0;
  logic [31:0] dst_val = '0;
  logic [31:0] src_val = '0;
  logic        res_valid, res_wen, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] res_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rrs_alu i_rrs_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_size(op_size), .dst_val(dst_val), .src_val(src_val),
    .res_valid(res_valid), .res_wen(res_wen), .res_val(res_val),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  logic [31:0] pats [12] = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFF, 32'h7FFF,
                             32'h8000, 32'hFFFF, 32'h7FFFFFFF, 32'h80000000,
                             32'hFFFFFFFF, 32'h12345A5C};

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 1:    return "R3";
      2:       return "R4";
      5:       return "R5";
      3, 4, 9: return "R6";
      6:       return "R7";
      7, 8:    return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic longint sgn(input longint x, input int w);
    return (x >= (64'sd1 <<< (w-1))) ? x - (64'sd1 <<< w) : x;
  endfunction

  // expected: {wen, n, z, v, c, val}
  task automatic model(input int op, input int sz, input longint d, input longint s,
                       output bit wen, output bit n, output bit z, output bit v,
                       output bit c, output longint val);
    int w;
    longint m, a, b, r, sr, cnt;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m = (64'sd1 <<< w) - 1;
    a = d & m;
    b = s & m;
    cnt = s & 63;
    v = 0; c = 0; r = 0;
    wen = (op <= 9) && (op != 2);
    case (op)
      0: begin
        r = (a + b) & m; c = ((a + b) >> w) != 0;
        sr = sgn(a, w) + sgn(b, w);
        v = (sr >= (64'sd1 <<< (w-1))) || (sr < -(64'sd1 <<< (w-1)));
      end
      1, 2, 5: begin
        if (op == 5) a = 0;
        r = (a - b) & m; c = a < b;
        sr = sgn(a, w) - sgn(b, w);
        v = (sr >= (64'sd1 <<< (w-1))) || (sr < -(64'sd1 <<< (w-1)));
      end
      3: r = a & b;
      4: r = a | b;
      9: r = b;
      6: begin
        if (cnt > 31) cnt = 31;
        r = (sgn(a, w) >>> cnt) & m;
      end
      7: r = (cnt > 31) ? 0 : ((a >> cnt) & m);
      8: r = (cnt > 31) ? 0 : ((a << cnt) & m);
      default: r = 0;
    endcase
    if (op <= 9) begin
      n = ((r >> (w-1)) & 1) != 0;
      z = (r == 0);
    end else begin
      n = 0; z = 0;
    end
    val = wen ? ((d & ~m & 64'hFFFFFFFF) | r) : d;
  endtask

  task automatic run_op(input int op, input int sz, input logic [31:0] d, input logic [31:0] s);
    bit wen, n, z, v, c;
    longint val;
    string t;
    int w;
    op_valid = 1'b1;
    op_code  = 4'(op);
    op_size  = 2'(sz);
    dst_val  = d;
    src_val  = s;
    model(op, sz, longint'(d), longint'(s), wen, n, z, v, c, val);
    t = tag_of(op);
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    @(negedge clk);
    check("R1", "valid", res_valid, 1);
    check(t, "wen", res_wen, wen);
    check(t, "val", res_val, val);
    check("R9", "n", flag_n, n);
    check("R9", "z", flag_z, z);
    check(t, "v", flag_v, v);
    check(t, "c", flag_c, c);
    if (wen && w < 32)  // R2 upper bits kept
      check("R2", "upper", longint'(res_val) >> w, longint'(d) >> w);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset valid", res_valid, 0);
    check("R1", "reset wen", res_wen, 0);
    check("R1", "reset val", res_val, 0);
    check("R1", "reset flags", {flag_n, flag_z, flag_v, flag_c}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (pats[i]) begin
      for (int op = 0; op < 16; op++) begin
        if (op >= 10 && op != 12 && op != 15) continue;
        for (int sz = 0; sz < 4; sz++)
          for (int j = 0; j < 12; j++)
            run_op(op, sz, pats[i], pats[j]);
      end
    end
    // shift count sweep: R7 and R8
    for (int op = 6; op <= 8; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int k = 0; k <= 70; k++) begin
          run_op(op, sz, 32'hFFFF_FF80, 32'(k));
          run_op(op, sz, 32'h8000_8081, 32'(k));
          run_op(op, sz, 32'h1234_5A5C, 32'(k) | 32'hFFFF_FF00);
        end
    // R1 idle cycle
    op_valid = 1'b0;
    @(negedge clk);
    check("R1", "idle valid", res_valid, 0);
    check("R1", "idle wen", res_wen, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule